// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Model

This block is a synthesizable model of a single-cycle-deselect pipelined synchronous burst SRAM. The internal array is small and set by parameters (256 words of four 9-bit bytes by default). A new address can be loaded through either of two strobes. One is the processor strobe, which the main chip enable gates. The other is the controller strobe, which ignores that gating. After the load, the advance input steps a 4-beat burst. The burst order is linear or interleaved, and a static mode input picks it. Reads go through two register stages: an address/command stage and an output data stage.

Writes are controlled by a global write enable or by a byte write enable qualified by per-byte selects. The bidirectional data bus appears as separate `din`, `dout` and `dout_en` ports, so a pad ring or a bench can build the tristate. Output enable and the sleep input act on `dout_en` without waiting for a clock. Sleep also freezes every other input while the array keeps its contents.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low, and after its release until a read has been registered, `dout_en` is 0.
- R2: A read whose address is registered on rising edge k puts that word on `dout` with `dout_en` high after edge k+1, and not earlier.
- R3: An edge accepting the processor strobe (`proc_strobe_n`=0, `ce_main_n`=0, chip enables active) always starts a read. `gwr_n`, `bwr_n` and `bsel_n` are ignored there and the addressed word is unchanged.
- R4: With `ce_main_n`=1, the processor strobe is ignored and a running burst continues. A controller strobe with `ce_main_n`=1 is still accepted and deselects the device.
- R5: On an edge where `ctrl_strobe_n`=0 and the processor strobe is not accepted, the write enables are sampled: no active byte write gives a read, any active byte write gives a write of `din` at `addr` on that edge.
- R6: `gwr_n`=0 in a write-capable cycle writes all four bytes whatever `bwr_n` and `bsel_n` are.
- R7: With `gwr_n`=1 and `bwr_n`=0, byte i (bits 9i+8..9i) is written exactly when `bsel_n[i]`=0; the other bytes keep their value.
- R8: `dout_en` is 0 while `oe_n`=1, and is 0 after any edge that registers a byte write even with `oe_n`=0.
- R9: While `sleep`=1, `dout_en` is 0 at once, all other inputs are ignored (no write happens), and the array keeps its contents.
- R10: `ce_hi` is active high and `ce_lo_n` active low. A strobe accepted while either is inactive deselects the device.
- R11: Single-cycle deselect: after a deselect registered on edge d, the read from edge d-1 is still driven after d, and `dout_en` is 0 after edge d+1.
- R12: In a burst, `adv_n`=0 on a cycle with both strobes high moves to the next beat. The low two address bits follow start+i mod 4 when `linear_burst`=1 and start XOR i when `linear_burst`=0. The upper bits are held.
- R13: With both strobes high and `adv_n`=1 the current burst address is accessed again. Continue cycles read or write according to the write enables on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| sleep | input | 1 | Asynchronous power-down; outputs off, inputs ignored |
| linear_burst | input | 1 | Static burst order select: 1 linear, 0 interleaved |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_main_n | input | 1 | Main chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| gwr_n | input | 1 | Global write enable, active low |
| bwr_n | input | 1 | Byte write enable, active low |
| bsel_n | input | 4 | Per-byte write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 8 | Word address |
| din | input | 36 | Write data |
| dout | output | 36 | Read data from the output register |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
The hardest case to reach from the ports is a command that lands while a burst is already running. Examples are a processor strobe blocked by the main enable, a controller strobe that deselects, and a write edge that follows a pending read. In each case the only visible difference is whether `dout_en` stays high one or two edges later. The bench therefore first starts a read and parks it in a suspended continue cycle, so the output is known to be driving. It then applies the command and samples `dout_en` on the edge where a correct and an incorrect design disagree. Burst order gets the same treatment: a burst is written through continue cycles, then read back from an unaligned start in both orders.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_DESEL = 2'd2,
      OP_CONT  = 2'd3
   } bs_op_e;

   // Low two bits of a burst beat: linear adds, interleaved XORs.
   function automatic logic [1:0] beat_bits(input logic [1:0] start,
                                            input logic [1:0] idx,
                                            input logic       lin);
      return lin ? 2'(start + idx) : (start ^ idx);
   endfunction
endpackage

// File: rtl/bsram_addr_ctr.sv
module bsram_addr_ctr #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic          linear,
   input  logic [AW-1:0] load_addr,
   output logic [AW-1:0] cur_addr,
   output logic [AW-1:0] nxt_addr
);
   import burst_sram_pkg::*;

   logic [AW-1:0] base_q;
   logic [1:0]    cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         base_q <= load_addr;
         cnt_q  <= '0;
      end else if (step) begin
         cnt_q  <= 2'(cnt_q + 2'd1);
      end
   end

   assign cur_addr = {base_q[AW-1:2], beat_bits(base_q[1:0], cnt_q, linear)};
   assign nxt_addr = {base_q[AW-1:2], beat_bits(base_q[1:0], 2'(cnt_q + 2'd1), linear)};
endmodule

// File: rtl/bsram_we_dec.sv
module bsram_we_dec #(
   parameter int NB = 4
) (
   input  logic          gwr_n,
   input  logic          bwr_n,
   input  logic [NB-1:0] bsel_n,
   output logic [NB-1:0] mask
);
   for (genvar i = 0; i < NB; i++) begin : g_byte
      assign mask[i] = !gwr_n || (!bwr_n && !bsel_n[i]);
   end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
   parameter int AW = 8,
   parameter int NB = 4,
   parameter int BW = 9
) (
   input  logic             clk,
   input  logic [NB-1:0]    we_mask,
   input  logic [AW-1:0]    waddr,
   input  logic [NB*BW-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [NB*BW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      logic [BW-1:0] lane [DEPTH];
      always_ff @(posedge clk) begin
         if (we_mask[i]) lane[waddr] <= wdata[i*BW +: BW];
      end
      assign rdata[i*BW +: BW] = lane[raddr];
   end
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
   parameter int AW = 8,
   parameter int NB = 4,
   parameter int BW = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep,
   input  logic             linear_burst,
   input  logic             proc_strobe_n,
   input  logic             ctrl_strobe_n,
   input  logic             adv_n,
   input  logic             ce_main_n,
   input  logic             ce_hi,
   input  logic             ce_lo_n,
   input  logic             gwr_n,
   input  logic             bwr_n,
   input  logic [NB-1:0]    bsel_n,
   input  logic             oe_n,
   input  logic [AW-1:0]    addr,
   input  logic [NB*BW-1:0] din,
   output logic [NB*BW-1:0] dout,
   output logic             dout_en
);
   import burst_sram_pkg::*;

   localparam int DW = NB * BW;

   if (AW < 3) begin : g_bad_aw
      $error("burst_sram: AW must leave address bits above the 4-beat burst");
   end
   if (NB < 1 || BW < 1) begin : g_bad_w
      $error("burst_sram: byte count and byte width must be positive");
   end

   bs_op_e        op;
   logic          p_take, c_take, chips_on, advance, is_read;
   logic [NB-1:0] dec_mask, wr_mask;
   logic [AW-1:0] cur_addr, nxt_addr, acc_addr, rd_addr_q;
   logic [DW-1:0] rdata, dout_q;
   logic          active_q, rd_pend_q, drv_q, wr_seen_q;

   assign p_take   = !sleep && !proc_strobe_n && !ce_main_n;
   assign c_take   = !sleep && !ctrl_strobe_n && !p_take;
   assign chips_on = !ce_main_n && ce_hi && !ce_lo_n;

   always_comb begin
      if (p_take || c_take) op = chips_on ? OP_LOAD : OP_DESEL;
      else if (!sleep && active_q) op = OP_CONT;
      else op = OP_IDLE;
   end

   bsram_we_dec #(.NB(NB)) u_dec (
      .gwr_n (gwr_n),
      .bwr_n (bwr_n),
      .bsel_n(bsel_n),
      .mask  (dec_mask)
   );

   assign wr_mask  = (p_take || !(op == OP_LOAD || op == OP_CONT)) ? '0 : dec_mask;
   assign is_read  = (op == OP_LOAD || op == OP_CONT) && (wr_mask == '0);
   assign advance  = (op == OP_CONT) && !adv_n;
   assign acc_addr = (op == OP_LOAD) ? addr : (advance ? nxt_addr : cur_addr);

   bsram_addr_ctr #(.AW(AW)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (op == OP_LOAD),
      .step     (advance),
      .linear   (linear_burst),
      .load_addr(addr),
      .cur_addr (cur_addr),
      .nxt_addr (nxt_addr)
   );

   bsram_array #(.AW(AW), .NB(NB), .BW(BW)) u_arr (
      .clk    (clk),
      .we_mask(wr_mask),
      .waddr  (acc_addr),
      .wdata  (din),
      .raddr  (rd_addr_q),
      .rdata  (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         rd_pend_q <= 1'b0;
         rd_addr_q <= '0;
         drv_q     <= 1'b0;
         wr_seen_q <= 1'b0;
         dout_q    <= '0;
      end else begin
         if (sleep) active_q <= 1'b0;
         else if (op == OP_LOAD) active_q <= 1'b1;
         else if (op == OP_DESEL) active_q <= 1'b0;
         rd_pend_q <= is_read;
         if (is_read) rd_addr_q <= acc_addr;
         drv_q     <= rd_pend_q && !sleep;
         wr_seen_q <= |wr_mask;
         if (rd_pend_q) dout_q <= rdata;
      end
   end

   assign dout    = dout_q;
   assign dout_en = drv_q && !wr_seen_q && !oe_n && !sleep;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
   parameter int NB = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sleep,
   input logic          oe_n,
   input logic          dout_en,
   input logic          proc_strobe_n,
   input logic          ctrl_strobe_n,
   input logic          ce_main_n,
   input logic          ce_hi,
   input logic          ce_lo_n,
   input logic          gwr_n,
   input logic [NB-1:0] wr_mask
);
   logic ctrl_gwrite;
   assign ctrl_gwrite = !sleep && !ctrl_strobe_n && proc_strobe_n && !ce_main_n
                        && ce_hi && !ce_lo_n && !gwr_n;

   p_sleep_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dout_en);

   p_sleep_nowr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (wr_mask == '0));

   p_oe_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dout_en);

   p_wr_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_gwrite |=> !dout_en);

   p_proc_nowr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !proc_strobe_n && !ce_main_n) |-> (wr_mask == '0));

   p_gwr_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_gwrite |-> (wr_mask == '1));
endmodule

bind burst_sram bsram_chk #(.NB(NB)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sleep        (sleep),
   .oe_n         (oe_n),
   .dout_en      (dout_en),
   .proc_strobe_n(proc_strobe_n),
   .ctrl_strobe_n(ctrl_strobe_n),
   .ce_main_n    (ce_main_n),
   .ce_hi        (ce_hi),
   .ce_lo_n      (ce_lo_n),
   .gwr_n        (gwr_n),
   .wr_mask      (wr_mask)
);

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
   localparam int AW = 8;
   localparam int NB = 4;
   localparam int BW = 9;
   localparam int DW = NB * BW;

   logic clk = 1'b0;
   logic rst_n, sleep, linear_burst, proc_strobe_n, ctrl_strobe_n, adv_n;
   logic ce_main_n, ce_hi, ce_lo_n, gwr_n, bwr_n, oe_n;
   logic [NB-1:0] bsel_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] din, dout;
   logic          dout_en;

   int nchk = 0;
   int nfail = 0;
   logic [DW-1:0] ref_mem [1 << AW];

   localparam logic [AW+DW-1:0] VEC [8] = '{
      {8'h03, 36'h1_2345_6789}, {8'h17, 36'hF_EDCB_A987},
      {8'h2A, 36'h0_0000_0001}, {8'h55, 36'h8_0000_0000},
      {8'h80, 36'hA_AAAA_AAAA}, {8'h9C, 36'h5_5555_5555},
      {8'hC1, 36'h3_C3C3_C3C3}, {8'hFF, 36'hF_FFFF_FFFF}
   };

   always #5 clk = ~clk;

   burst_sram #(.AW(AW), .NB(NB), .BW(BW)) dut (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .linear_burst(linear_burst),
      .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n), .adv_n(adv_n),
      .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n), .gwr_n(gwr_n),
      .bwr_n(bwr_n), .bsel_n(bsel_n), .oe_n(oe_n), .addr(addr), .din(din),
      .dout(dout), .dout_en(dout_en)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   task automatic chk(input bit ok, input string req,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic wr_off();
      gwr_n = 1'b1; bwr_n = 1'b1; bsel_n = '1; adv_n = 1'b1;
   endtask

   // deselect through the controller strobe with ce_hi low
   task automatic idle();
      wr_off(); ctrl_strobe_n = 1'b0; proc_strobe_n = 1'b1;
      ce_main_n = 1'b0; ce_hi = 1'b0; ce_lo_n = 1'b0;
   endtask

   // continue cycle, both strobes high, burst suspended
   task automatic hold();
      wr_off(); ctrl_strobe_n = 1'b1; proc_strobe_n = 1'b1;
      ce_main_n = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0;
   endtask

   task automatic ref_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic g, input logic bw, input logic [NB-1:0] bs);
      for (int i = 0; i < NB; i++)
         if (!g || (!bw && !bs[i])) ref_mem[a][i*BW +: BW] = d[i*BW +: BW];
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic g, input logic bw, input logic [NB-1:0] bs);
      hold(); ctrl_strobe_n = 1'b0; addr = a; din = d;
      gwr_n = g; bwr_n = bw; bsel_n = bs;
      tick();
      ref_write(a, d, g, bw, bs);
      idle(); tick();
   endtask

   task automatic proc_load(input logic [AW-1:0] a);
      hold(); proc_strobe_n = 1'b0; addr = a;
   endtask

   task automatic rd(input logic [AW-1:0] a, input string req);
      proc_load(a); tick();
      chk(!dout_en, {req, " R2 latency"}, {35'd0, dout_en}, '0);
      idle(); tick();
      chk(dout_en && dout === ref_mem[a], req, dout, ref_mem[a]);
      tick();
      chk(!dout_en, {req, " R11 off"}, {35'd0, dout_en}, '0);
   endtask

   task automatic burst_rd(input logic [AW-1:0] b, input logic lin, input string req);
      logic [AW-1:0] ea;
      linear_burst = lin;
      proc_load(b); tick();
      hold(); adv_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         if (i == 3) adv_n = 1'b1;
         tick();
         ea = {b[AW-1:2], lin ? 2'(b[1:0] + 2'(i)) : (b[1:0] ^ 2'(i))};
         chk(dout_en && dout === ref_mem[ea], req, dout, ref_mem[ea]);
      end
      idle(); tick(); tick();
   endtask

   // strobe with one chip enable inactive during a driving read
   task automatic desel_probe(input logic hi, input logic lo_n, input string req);
      proc_load(VEC[2][DW +: AW]); tick();
      hold(); tick();
      chk(dout_en, {req, " pre"}, {35'd0, dout_en}, 36'd1);
      proc_strobe_n = 1'b0; ce_hi = hi; ce_lo_n = lo_n; tick();
      hold(); tick();
      chk(!dout_en, req, {35'd0, dout_en}, '0);
      idle(); tick();
   endtask

   logic [AW-1:0] a0, b0;

   initial begin
      rst_n = 1'b0; sleep = 1'b0; linear_burst = 1'b1; oe_n = 1'b0;
      addr = '0; din = '0; idle();
      repeat (3) tick();
      chk(!dout_en, "R1 in reset", {35'd0, dout_en}, '0);
      rst_n = 1'b1; tick();
      chk(!dout_en, "R1 after reset", {35'd0, dout_en}, '0);

      // vector table: controller-strobe global writes, then reads
      foreach (VEC[i]) wr(VEC[i][DW +: AW], VEC[i][DW-1:0], 1'b0, 1'b1, '1);
      foreach (VEC[i]) rd(VEC[i][DW +: AW], "R2 R5 vector");
      a0 = VEC[0][DW +: AW];
      b0 = VEC[1][DW +: AW];

      // R7 byte writes: bytes 0 and 2 only, then byte 3 only
      wr(a0, 36'hF_FFFF_FFFF, 1'b1, 1'b0, 4'b1010);
      rd(a0, "R7 bytes0,2");
      wr(a0, 36'h0_0000_0000, 1'b1, 1'b0, 4'b0111);
      rd(a0, "R7 byte3");

      // R6 global write overrides byte selects
      wr(b0, 36'h9_8765_4321, 1'b0, 1'b1, 4'b1111);
      rd(b0, "R6");

      // R5 controller strobe with byte enable but no select is a read
      hold(); ctrl_strobe_n = 1'b0; bwr_n = 1'b0; addr = b0; din = '0; tick();
      idle(); tick();
      chk(dout_en && dout === ref_mem[b0], "R5 ctrl read", dout, ref_mem[b0]);
      tick();

      // R3 processor strobe ignores write enables
      proc_load(a0); gwr_n = 1'b0; bwr_n = 1'b0; bsel_n = '0; din = ~ref_mem[a0];
      tick(); idle(); tick();
      chk(dout_en && dout === ref_mem[a0], "R3 read issued", dout, ref_mem[a0]);
      tick();
      rd(a0, "R3 unchanged");

      // R4 blocked processor strobe from deselected state
      proc_load(a0); ce_main_n = 1'b1; tick();
      hold(); tick();
      chk(!dout_en, "R4 proc blocked", {35'd0, dout_en}, '0);
      // R4 controller strobe with main enable off deselects
      proc_load(a0); tick(); hold(); tick();
      ctrl_strobe_n = 1'b0; ce_main_n = 1'b1; tick();
      hold(); tick();
      chk(!dout_en, "R4 ctrl desel", {35'd0, dout_en}, '0);
      // R4 blocked processor strobe does not stop a running read
      proc_load(a0); tick(); hold(); tick();
      proc_strobe_n = 1'b0; ce_main_n = 1'b1; addr = b0; tick();
      hold(); tick();
      chk(dout_en && dout === ref_mem[a0], "R4 burst kept", dout, ref_mem[a0]);
      idle(); tick(); tick();

      // R10 chip enable polarity
      desel_probe(1'b0, 1'b0, "R10 ce_hi low");
      desel_probe(1'b1, 1'b1, "R10 ce_lo_n high");

      // R8 output enable and write turn-off
      proc_load(a0); tick(); hold(); tick();
      oe_n = 1'b1; #1;
      chk(!dout_en, "R8 oe off", {35'd0, dout_en}, '0);
      oe_n = 1'b0; #1;
      chk(dout_en, "R8 oe on", {35'd0, dout_en}, 36'd1);
      hold(); ctrl_strobe_n = 1'b0; gwr_n = 1'b0; addr = b0; din = 36'h1_1111_2222;
      tick();
      ref_write(b0, 36'h1_1111_2222, 1'b0, 1'b1, '1);
      chk(!dout_en, "R8 write off", {35'd0, dout_en}, '0);
      idle(); tick();
      rd(b0, "R8 write data");

      // R9 sleep
      proc_load(a0); tick(); hold(); tick();
      sleep = 1'b1; #1;
      chk(!dout_en, "R9 sleep hiz", {35'd0, dout_en}, '0);
      hold(); ctrl_strobe_n = 1'b0; gwr_n = 1'b0; addr = a0; din = 36'h7_7777_7777;
      tick(); tick();
      chk(!dout_en, "R9 sleep hold", {35'd0, dout_en}, '0);
      idle(); sleep = 1'b0; tick(); tick();
      rd(a0, "R9 contents kept");

      // R13 burst write through continue cycles, then readback
      linear_burst = 1'b1;
      hold(); ctrl_strobe_n = 1'b0; gwr_n = 1'b0; addr = 8'h40; din = 36'h0_4000_0000;
      tick();
      ref_mem[8'h40] = 36'h0_4000_0000;
      hold(); gwr_n = 1'b0; adv_n = 1'b0;
      for (int i = 1; i < 4; i++) begin
         din = 36'h0_4000_0000 + 36'(i * 36'h111);
         tick();
         ref_mem[8'h40 + 8'(i)] = din;
      end
      idle(); tick();
      for (int i = 0; i < 4; i++) rd(8'h40 + 8'(i), "R13 burst write");

      // R12 burst order from an unaligned start
      burst_rd(8'h41, 1'b1, "R12 R13 linear");
      burst_rd(8'h41, 1'b0, "R12 R13 interleaved");
      burst_rd(8'h43, 1'b0, "R12 interleaved from 3");

      summary();
   end
endmodule